// File: doc/BRIEF.md
# Cyclic Descriptor DMA Channel

A single DMA channel that moves data between one peripheral and memory in flyby style. Each peripheral request produces one single-address bus transaction. The channel is described by one descriptor with four fields: the current buffer pointer, the remaining byte count, a 32-bit attribute word and the base size of the buffer. Software loads these fields through a small register write port and then switches the channel on.

After every transaction the pointer moves forward by the block size and the remaining count drops by the same amount. When the count runs out, it reloads from the base size. In ring mode the pointer also returns to the address captured when the channel was enabled, so the buffer is reused without software help. In one-shot mode the channel turns itself off instead. A buffer-full interrupt, enabled from the attribute word, latches at that point and stays set until software clears it. A final transfer that finds fewer bytes left than one block is marked as an error.

Top module: `dma_ring_chan`

## Requirements
- R1: After reset, bus_req, bus_err, irq and chan_on are 0, and bus_addr and bus_kind are 0.
- R2: A transaction starts when per_req is 1, chan_on is 1 and wr_en is 0 at a clock edge. In the cycle after that edge, bus_req is 1 for one cycle. bus_addr then holds the pointer value from before the beat, and bus_kind holds attribute bits [3:2].
- R3: After each beat the pointer grows by BLK bytes (4 by default), unless a wrap takes place as described in R5.
- R4: Each beat lowers the remaining count by BLK. A beat that brings the count to 0 is a zero event, and the count then reloads from the base size. The register selects are: 0 pointer, 1 remaining count, 2 attribute, 3 base size, 4 control, 5 status.
- R5: With attribute bit 0 set (ring mode), a zero event returns the pointer to the value it held when control bit 0 was last written as 1. The channel stays on.
- R6: With attribute bit 0 clear, a zero event turns chan_on off. The channel then ignores per_req until control bit 0 is written as 1 again.
- R7: With attribute bit 1 set, a zero event sets irq. irq stays set through later beats and later zero events. It is cleared only by a status write with data bit 0 equal to 1. With attribute bit 1 clear, irq is never set.
- R8: A beat that finds less than BLK bytes remaining (including 0) drives bus_err to 1 alongside bus_req. It forces the count to zero, which is a zero event. bus_err is never 1 without bus_req.
- R9: In a cycle with wr_en set, no transaction is issued even if per_req is 1, and the pointer and count do not move.
- R10: While chan_on is 0, per_req causes no bus_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (see R4) |
| wr_data | input | 32 | Register write data |
| per_req | input | 1 | Peripheral transfer request, one beat per sampled cycle |
| bus_req | output | 1 | Bus transaction valid for this cycle |
| bus_addr | output | 16 | Address of the transaction |
| bus_kind | output | 2 | Transaction type from attribute bits [3:2] |
| bus_err | output | 1 | Short final transfer flag |
| irq | output | 1 | Sticky buffer-full interrupt |
| chan_on | output | 1 | Channel enabled |

## Verification
The assertions assume that per_req and the write port are driven with clean, synchronous levels. They also assume that a status clear is only requested through the normal write port. No other path into the flag is relied on. The stimulus changes inputs only on the falling clock edge and never drives per_req together with a write, except in the one test that checks the write-wins rule. Sweeps cover both modes, both interrupt settings and several base sizes. One base size is not a multiple of the block, and one is zero, so the short-transfer path is reached from both a partial count and an empty count.

// File: rtl/dma_ring_pkg.sv
package dma_ring_pkg;
    typedef enum logic [2:0] {
        SEL_PTR  = 3'd0,
        SEL_LEFT = 3'd1,
        SEL_ATTR = 3'd2,
        SEL_BASE = 3'd3,
        SEL_CTRL = 3'd4,
        SEL_STAT = 3'd5
    } reg_sel_e;

    localparam int ATTR_RING_BIT = 0;
    localparam int ATTR_IEN_BIT  = 1;
    localparam int ATTR_KIND_LO  = 2;
    localparam int KIND_W        = 2;
endpackage

// File: rtl/dma_ring_step.sv
module dma_ring_step #(
    parameter int AW  = 16,
    parameter int SW  = 12,
    parameter int BLK = 4
) (
    input  logic [AW-1:0] cur_addr,
    input  logic [SW-1:0] cur_left,
    input  logic [SW-1:0] base_left,
    input  logic [AW-1:0] ring_start,
    input  logic          ring_mode,
    output logic [AW-1:0] nxt_addr,
    output logic [SW-1:0] nxt_left,
    output logic          short_xfer,
    output logic          zero_evt
);
    localparam logic [SW-1:0] BLK_S = SW'(BLK);
    localparam logic [AW-1:0] BLK_A = AW'(BLK);

    logic [SW-1:0] dec_left;
    logic [AW-1:0] inc_addr;

    always_comb begin
        short_xfer = (cur_left < BLK_S);
        dec_left   = short_xfer ? '0 : (cur_left - BLK_S);
        zero_evt   = (dec_left == '0);
        inc_addr   = cur_addr + BLK_A;
        nxt_left   = zero_evt ? base_left : dec_left;
        nxt_addr   = (zero_evt && ring_mode) ? ring_start : inc_addr;
    end
endmodule

// File: rtl/dma_ring_flag.sv
module dma_ring_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/dma_ring_chan.sv
module dma_ring_chan
    import dma_ring_pkg::*;
#(
    parameter int AW  = 16,
    parameter int SW  = 12,
    parameter int DW  = 32,
    parameter int BLK = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          per_req,
    output logic          bus_req,
    output logic [AW-1:0] bus_addr,
    output logic [KIND_W-1:0] bus_kind,
    output logic          bus_err,
    output logic          irq,
    output logic          chan_on
);
    typedef struct packed {
        logic [AW-1:0]     addr;
        logic [SW-1:0]     left;
        logic [DW-1:0]     attr;
        logic [SW-1:0]     base;
        logic [AW-1:0]     start;
        logic              en;
        logic              req;
        logic [AW-1:0]     baddr;
        logic [KIND_W-1:0] kind;
        logic              err;
    } chan_st_t;

    chan_st_t st_d, st_q;

    logic [AW-1:0] step_addr;
    logic [SW-1:0] step_left;
    logic          step_short;
    logic          step_zero;
    logic          fire;
    logic          irq_set;
    logic          irq_clr;
    logic          unused_bits;

    assign unused_bits = ^{wr_data[DW-1:AW], st_q.attr[DW-1:ATTR_KIND_LO+KIND_W]};

    dma_ring_step #(.AW(AW), .SW(SW), .BLK(BLK)) u_step (
        .cur_addr   (st_q.addr),
        .cur_left   (st_q.left),
        .base_left  (st_q.base),
        .ring_start (st_q.start),
        .ring_mode  (st_q.attr[ATTR_RING_BIT]),
        .nxt_addr   (step_addr),
        .nxt_left   (step_left),
        .short_xfer (step_short),
        .zero_evt   (step_zero)
    );

    always_comb begin
        fire    = per_req && st_q.en && !wr_en;
        irq_set = fire && step_zero && st_q.attr[ATTR_IEN_BIT];
        irq_clr = wr_en && (wr_sel == SEL_STAT) && wr_data[0];

        st_d      = st_q;
        st_d.req  = 1'b0;
        st_d.err  = 1'b0;

        if (wr_en) begin
            unique case (reg_sel_e'(wr_sel))
                SEL_PTR:  st_d.addr = wr_data[AW-1:0];
                SEL_LEFT: st_d.left = wr_data[SW-1:0];
                SEL_ATTR: st_d.attr = wr_data;
                SEL_BASE: st_d.base = wr_data[SW-1:0];
                SEL_CTRL: begin
                    st_d.en = wr_data[0];
                    if (wr_data[0]) st_d.start = st_q.addr;
                end
                default: ;
            endcase
        end else if (fire) begin
            st_d.req   = 1'b1;
            st_d.baddr = st_q.addr;
            st_d.kind  = st_q.attr[ATTR_KIND_LO +: KIND_W];
            st_d.err   = step_short;
            st_d.addr  = step_addr;
            st_d.left  = step_left;
            if (step_zero && !st_q.attr[ATTR_RING_BIT]) st_d.en = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    dma_ring_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (irq_set),
        .clr_i  (irq_clr),
        .flag_o (irq)
    );

    assign bus_req  = st_q.req;
    assign bus_addr = st_q.baddr;
    assign bus_kind = st_q.kind;
    assign bus_err  = st_q.err;
    assign chan_on  = st_q.en;
endmodule

// File: rtl/dma_ring_chk.sv
module dma_ring_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [2:0]    wr_sel,
    input logic [DW-1:0] wr_data,
    input logic          per_req,
    input logic          bus_req,
    input logic          bus_err,
    input logic          irq,
    input logic          chan_on
);
    logic stat_clr;
    logic unused_chk;
    assign stat_clr   = wr_en && (wr_sel == 3'd5) && wr_data[0];
    assign unused_chk = ^wr_data[DW-1:1];

    AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> $past(per_req && chan_on && !wr_en)) else $error("AST_REQ_CAUSE"); // R2
    AST_WRITE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !bus_req) else $error("AST_WRITE_BLOCKS"); // R9
    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_on |=> !bus_req) else $error("AST_OFF_SILENT"); // R10
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !stat_clr) |=> irq) else $error("AST_IRQ_HOLD"); // R7
    AST_ERR_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> bus_req) else $error("AST_ERR_WITH_REQ"); // R8
endmodule

bind dma_ring_chan dma_ring_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .per_req (per_req),
    .bus_req (bus_req),
    .bus_err (bus_err),
    .irq     (irq),
    .chan_on (chan_on)
);

// File: tb/test_dma_ring_chan.sv
module test_dma_ring_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        per_req = 1'b0;
    logic        bus_req;
    logic [15:0] bus_addr;
    logic [1:0]  bus_kind;
    logic        bus_err;
    logic        irq;
    logic        chan_on;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int m_addr, m_left, m_base, m_start, m_kind;
    bit m_on, m_irq, m_ring, m_ien;

    always #5 clk = ~clk;

    dma_ring_chan i_dma_ring_chan (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .per_req(per_req), .bus_req(bus_req), .bus_addr(bus_addr), .bus_kind(bus_kind),
        .bus_err(bus_err), .irq(irq), .chan_on(chan_on)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int sel, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'(sel); wr_data = 32'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic beat();
        int exp_addr;
        bit sh, zr;
        int raw;
        @(negedge clk);
        per_req = 1'b1;
        @(negedge clk);
        per_req = 1'b0;
        if (!m_on) begin
            chk(bus_req == 1'b0, "R10 req while off", int'(bus_req), 0);
            return;
        end
        exp_addr = m_addr;
        sh  = (m_left < 4);
        raw = sh ? 0 : m_left - 4;
        zr  = (raw == 0);
        m_addr = (m_addr + 4) & 16'hFFFF;
        if (zr) begin
            m_left = m_base;
            if (m_ring) m_addr = m_start;
            else        m_on = 1'b0;
            if (m_ien)  m_irq = 1'b1;
        end else begin
            m_left = raw;
        end
        chk(bus_req == 1'b1, "R2 bus_req", int'(bus_req), 1);
        chk(int'(bus_addr) == exp_addr, "R3 R5 bus_addr", int'(bus_addr), exp_addr);
        chk(int'(bus_kind) == m_kind, "R2 bus_kind", int'(bus_kind), m_kind);
        chk(bus_err == sh, "R8 bus_err", int'(bus_err), int'(sh));
        chk(irq == m_irq, "R7 irq", int'(irq), int'(m_irq));
        chk(chan_on == m_on, "R6 chan_on", int'(chan_on), int'(m_on));
    endtask

    task automatic setup(input int start, input int base, input bit ring, input bit ien, input int kind);
        m_addr = start; m_left = base; m_base = base; m_start = start;
        m_ring = ring; m_ien = ien; m_kind = kind; m_on = 1'b1;
        wr(0, start);
        wr(1, base);
        wr(3, base);
        wr(2, (kind << 2) | (int'(ien) << 1) | int'(ring));
        wr(4, 1);
        chk(chan_on == 1'b1, "R4 enable", int'(chan_on), 1);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int bases[4] = '{0, 4, 6, 12};
        repeat (3) @(negedge clk);
        chk(bus_req == 0 && bus_err == 0 && irq == 0 && chan_on == 0, "R1 reset flags",
            int'({bus_req, bus_err, irq, chan_on}), 0);
        chk(bus_addr == 0 && bus_kind == 0, "R1 reset bus", int'(bus_addr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        m_on = 1'b0; m_irq = 1'b0;
        beat();

        for (int r = 0; r < 2; r++)
            for (int ie = 0; ie < 2; ie++)
                for (int b = 0; b < 4; b++) begin
                    setup(16'h0100 + b * 64 + r * 16, bases[b], bit'(r), bit'(ie), (b + r) & 3);
                    for (int n = 0; n < 9; n++) beat();
                    if (m_irq) begin
                        wr(5, 1);
                        m_irq = 1'b0;
                        chk(irq == 1'b0, "R7 clear", int'(irq), 0);
                    end
                end

        setup(16'h0200, 8, 1'b0, 1'b1, 1);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'd6; wr_data = 32'd0; per_req = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; per_req = 1'b0;
        chk(bus_req == 1'b0, "R9 write blocks beat", int'(bus_req), 0);
        beat();
        beat();
        wr(5, 0);
        chk(irq == 1'b1, "R7 clear needs bit0", int'(irq), 1);
        wr(5, 1);
        m_irq = 1'b0;
        beat();
        wr(4, 1);
        m_on = 1'b1;
        m_left = m_base;
        beat();
        @(negedge clk);
        chk(bus_req == 1'b0, "R2 single cycle", int'(bus_req), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule